// File: doc/BRIEF.md
# Unaligned Load/Store Bus Sequencer

This block sits between a load/store requester and a 32-bit memory bus with a 20-bit byte address. The requester asks for a byte, a word (two bytes) or a doubleword (four bytes), to be read or written at any byte address. The block drives a bus address with its low two bits cleared and one byte enable for each of the four data lanes. Lane i carries the byte whose address has low bits equal to i. An item that fits inside one aligned group of four bytes moves in a single bus cycle. An item that runs past the end of such a group moves in two cycles: the lower group first, then the group that follows it. Only the lanes holding the item's bytes are enabled in each cycle.

Data is little-endian: byte k of the item sits at address `addr + k`, and it is byte k (bits 8k+7..8k) of the request or response data. For a write, the block moves the bytes onto their lanes. For a read, it collects the lanes from one or both cycles and returns the item right-aligned, with the bits above its size set to zero. The requester and the bus each use a valid/ready handshake. The response is a one-cycle pulse, and the requester may not stall it.

Top module: `lane_split_seq`

## Requirements
- R1: Out of reset, `req_ready` is 1, and `bus_valid` and `rsp_valid` are 0.
- R2: `req_size` is coded as 0 for a byte, 1 for a word and 2 for a doubleword. An access with `(addr mod 4) + bytes <= 4` takes one bus cycle. That cycle uses `bus_addr = addr` with bits 1..0 cleared, and `bus_be` has bit i set exactly for lanes `(addr mod 4) .. (addr mod 4)+bytes-1`.
- R3: An access with `(addr mod 4) + bytes > 4` takes two bus cycles. The first is at the lower group, with lanes `addr mod 4` through 3 enabled. The second is at that address plus 4, with lanes 0 through `(addr mod 4)+bytes-5` enabled.
- R4: On a write, byte k of `req_wdata` is driven on lane `(addr+k) mod 4`, in the cycle whose group contains `addr+k`.
- R5: A read returns on `rsp_rdata`, as bits 8k+7..8k, the byte that the bus returned for address `addr+k`, for every k below the size. All higher bits are 0. A write returns 0 on `rsp_rdata`.
- R6: The second cycle's address wraps modulo 2^20, so an access starting at FFFFEh uses groups FFFFCh and 00000h.
- R7: `req_ready` stays 0 from the cycle after acceptance until the cycle after the final bus handshake. While `bus_valid` is 1 and `bus_ready` is 0, `bus_addr`, `bus_be`, `bus_write` and `bus_wdata` hold their values.
- R8: `rsp_valid` pulses for exactly one cycle per accepted request. It rises in the cycle after the final bus handshake and never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword (3 treated as doubleword) |
| req_addr | input | 20 | Byte address of the item's lowest byte |
| req_wdata | input | 32 | Write item, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read item, right-aligned and zero-extended |
| bus_valid | output | 1 | Bus cycle requested |
| bus_ready | input | 1 | Bus completes the cycle |
| bus_write | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Group address, bits 1..0 zero |
| bus_be | output | 4 | Lane enables |
| bus_wdata | output | 32 | Write data on lanes |
| bus_rdata | input | 32 | Read data on lanes, valid at the handshake |

## Verification
The hardest case to reach is a two-cycle access whose second cycle stalls, and in particular the wrap from FFFFCh to 00000h. The bench's bus model returns bytes from a small memory indexed by the low address bits. That memory is consistent for both wrapped groups, so wrapped data can be checked byte by byte. A slow mode withholds `bus_ready` on alternate cycles, which holds split accesses in both cycles while the hold-steady property is checked.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;

    // number of bytes an access moves; code 3 is treated as the widest size
    function automatic int size_bytes(input logic [1:0] sz, input int nb);
        case (sz)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return nb;
        endcase
    endfunction

endpackage

// File: rtl/lane_plan.sv
module lane_plan
    import lane_split_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [NB-1:0]     be_lo,
    output logic [NB-1:0]     be_hi,
    output logic [DATA_W-1:0] wd_lo,
    output logic [DATA_W-1:0] wd_hi,
    output logic              split
);
    int                  nbytes;
    logic [2*NB-1:0]     span;
    logic [2*DATA_W-1:0] wide;

    assign nbytes = size_bytes(size, NB);

    // lanes across two adjacent groups that the item occupies
    for (genvar j = 0; j < 2*NB; j++) begin : g_span
        assign span[j] = (j >= int'(offset)) && (j < int'(offset) + nbytes);
    end

    assign be_lo = span[NB-1:0];
    assign be_hi = span[2*NB-1:NB];
    assign split = |be_hi;

    assign wide  = {{DATA_W{1'b0}}, wdata} << {offset, 3'b000};
    assign wd_lo = wide[DATA_W-1:0];
    assign wd_hi = wide[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/read_merge.sv
module read_merge
    import lane_split_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] rdata
);
    int                  nbytes;
    logic [2*DATA_W-1:0] shifted;

    assign nbytes  = size_bytes(size, NB);
    assign shifted = {hi, lo} >> {offset, 3'b000};

    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign rdata[8*k +: 8] = (k < nbytes) ? shifted[8*k +: 8] : 8'h00;
    end

endmodule

// File: rtl/lane_split_seq.sv
module lane_split_seq
    import lane_split_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB),
    localparam int IDX_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [NB-1:0]     bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        seq_state_e        st;
        logic              wr;
        logic [1:0]        sz;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] rdata;
        logic              rsp;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NB-1:0]     be_lo, be_hi;
    logic [DATA_W-1:0] wd_lo, wd_hi, merged, m_lo, m_hi;
    logic              split, second, ack;
    logic [IDX_W-1:0]  grp_idx;

    lane_plan #(.DATA_W(DATA_W)) i_plan (
        .offset (r_q.addr[OFF_W-1:0]),
        .size   (r_q.sz),
        .wdata  (r_q.wdata),
        .be_lo  (be_lo),
        .be_hi  (be_hi),
        .wd_lo  (wd_lo),
        .wd_hi  (wd_hi),
        .split  (split)
    );

    // a single-cycle read takes its lanes straight from the bus
    assign m_lo = split ? r_q.lo : bus_rdata;
    assign m_hi = split ? bus_rdata : '0;

    read_merge #(.DATA_W(DATA_W)) i_merge (
        .lo     (m_lo),
        .hi     (m_hi),
        .offset (r_q.addr[OFF_W-1:0]),
        .size   (r_q.sz),
        .rdata  (merged)
    );

    assign second    = (r_q.st == ST_SECOND);
    assign grp_idx   = r_q.addr[ADDR_W-1:OFF_W] + {{(IDX_W-1){1'b0}}, second};
    assign req_ready = (r_q.st == ST_IDLE);
    assign bus_valid = (r_q.st != ST_IDLE);
    assign bus_write = r_q.wr;
    assign bus_addr  = {grp_idx, {OFF_W{1'b0}}};
    assign bus_be    = second ? be_hi : be_lo;
    assign bus_wdata = second ? wd_hi : wd_lo;
    assign rsp_valid = r_q.rsp;
    assign rsp_rdata = r_q.rdata;
    assign ack       = bus_valid && bus_ready;

    always_comb begin
        r_d     = r_q;
        r_d.rsp = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_FIRST;
                    r_d.wr    = req_write;
                    r_d.sz    = req_size;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                end
            end
            ST_FIRST: begin
                if (ack) begin
                    if (split) begin
                        r_d.st = ST_SECOND;
                        r_d.lo = bus_rdata;
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.rsp   = 1'b1;
                        r_d.rdata = r_q.wr ? '0 : merged;
                    end
                end
            end
            ST_SECOND: begin
                if (ack) begin
                    r_d.st    = ST_IDLE;
                    r_d.rsp   = 1'b1;
                    r_d.rdata = r_q.wr ? '0 : merged;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2: every bus cycle is group-aligned and enables at least one lane
    a_r2_group_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[OFF_W-1:0] == '0) && (bus_be != '0));

    // R3: a second cycle always starts at lane 0
    a_r3_second_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
        second |-> bus_be[0]);

    // R3: the first half of a split access reaches the top lane
    a_r3_first_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !second && split) |-> bus_be[NB-1]);

    // R6: the second group follows the first, modulo the address space
    a_r6_next_group: assert property (@(posedge clk) disable iff (!rst_n)
        (second && $past(bus_valid && !second)) |->
            (bus_addr == ADDR_W'($past(bus_addr) + ADDR_W'(NB))));

    // R7: a stalled bus cycle keeps its attributes
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_addr) && $stable(bus_be)
            && $stable(bus_wdata) && $stable(bus_write));

    // R7: no second request right after an acceptance
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: a response follows a bus handshake and lasts one cycle
    a_r8_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_valid && bus_ready));

    a_r8_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_lane_split_seq.sv
module test_lane_split_seq;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [19:0] a;
        logic [31:0] d;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd2, 20'h00010, 32'h11223344},
        '{1'b0, 2'd2, 20'h00010, 32'h0},
        '{1'b1, 2'd2, 20'h00021, 32'h0123ABCD},
        '{1'b0, 2'd2, 20'h00021, 32'h0},
        '{1'b0, 2'd1, 20'h00023, 32'h0},
        '{1'b1, 2'd1, 20'h00032, 32'h00005AF0},
        '{1'b0, 2'd1, 20'h00032, 32'h0},
        '{1'b1, 2'd1, 20'h00043, 32'h00002C96},
        '{1'b0, 2'd2, 20'h00042, 32'h0},
        '{1'b0, 2'd0, 20'h00045, 32'h0},
        '{1'b1, 2'd0, 20'h00057, 32'h000000A5},
        '{1'b0, 2'd2, 20'h00054, 32'h0},
        '{1'b1, 2'd2, 20'h00063, 32'hCAFEBABE},
        '{1'b0, 2'd2, 20'h00063, 32'h0},
        '{1'b0, 2'd0, 20'h00066, 32'h0},
        '{1'b0, 2'd1, 20'h00061, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, bus_valid, bus_write;
    logic [31:0] rsp_rdata, bus_wdata;
    logic [19:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;

    int   checks = 0, fails = 0, ncyc = 0, stall_seen = 0;
    logic slow = 1'b0, tick = 1'b0;
    logic [19:0] addr_log [2];
    logic [3:0]  be_log [2];
    logic [7:0]  bmem [256];
    logic [7:0]  refb [256];

    logic        hold_pend = 1'b0;
    logic [19:0] h_addr;
    logic [3:0]  h_be;
    logic [31:0] h_wd;

    always #2 clk = ~clk;

    lane_split_seq i_lane_split_seq (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_size, .req_addr,
        .req_wdata, .rsp_valid, .rsp_rdata, .bus_valid, .bus_ready, .bus_write,
        .bus_addr, .bus_be, .bus_wdata, .bus_rdata
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bus model: answers away from the clock edge
    always @(negedge clk) begin
        tick      <= ~tick;
        bus_ready <= bus_valid && (!slow || tick);
        bus_rdata <= {bmem[{bus_addr[7:2], 2'd3}], bmem[{bus_addr[7:2], 2'd2}],
                      bmem[{bus_addr[7:2], 2'd1}], bmem[{bus_addr[7:2], 2'd0}]};
    end

    always @(posedge clk) begin
        if (hold_pend) begin
            chk(bus_valid && bus_addr == h_addr && bus_be == h_be && bus_wdata == h_wd,
                "R7 hold on stall", {12'h0, bus_addr}, {12'h0, h_addr});
            hold_pend = 1'b0;
        end
        if (bus_valid && !bus_ready) begin
            hold_pend = 1'b1;
            stall_seen++;
            h_addr = bus_addr; h_be = bus_be; h_wd = bus_wdata;
        end
        if (bus_valid && bus_ready) begin
            if (ncyc < 2) begin
                addr_log[ncyc] = bus_addr;
                be_log[ncyc]   = bus_be;
            end
            ncyc++;
            if (bus_write)
                for (int i = 0; i < 4; i++)
                    if (bus_be[i]) bmem[{bus_addr[7:2], 2'(i)}] = bus_wdata[8*i +: 8];
        end
    end

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // expected lane mask of cycle c, byte by byte from the address
    function automatic logic [3:0] exp_be(input logic [19:0] a, input int n, input int c);
        logic [3:0] m = '0;
        for (int k = 0; k < n; k++) begin
            logic [19:0] ba = a + 20'(k);
            int cyc = (ba[19:2] != a[19:2]) ? 1 : 0;
            if (cyc == c) m[ba[1:0]] = 1'b1;
        end
        return m;
    endfunction

    task automatic run(input vec_t v, input string tag);
        int n = nbytes(v.sz);
        int ecyc = ((int'(v.a[1:0]) + n) > 4) ? 2 : 1;
        logic [31:0] exp_rd = '0;
        bit busy_bad = 0;
        int guard = 0;
        logic [31:0] rd;
        for (int k = 0; k < n; k++) exp_rd[8*k +: 8] = refb[8'(v.a + 20'(k))];
        if (v.wr) begin
            for (int k = 0; k < n; k++) refb[8'(v.a + 20'(k))] = v.d[8*k +: 8];
            exp_rd = '0;
        end
        @(negedge clk);
        ncyc = 0;
        req_valid = 1'b1; req_write = v.wr; req_size = v.sz;
        req_addr = v.a; req_wdata = v.d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 50) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            guard++;
        end
        rd = rsp_rdata;
        chk(rsp_valid, {tag, " R8 response arrives"}, 32'(rsp_valid), 32'd1);
        chk(!busy_bad && req_ready, {tag, " R7 ready low while busy"}, 32'(busy_bad), 32'd0);
        chk(ncyc == ecyc, {tag, ecyc == 2 ? " R3 two cycles" : " R2 one cycle"},
            32'(ncyc), 32'(ecyc));
        chk(addr_log[0] == {v.a[19:2], 2'b00} && be_log[0] == exp_be(v.a, n, 0),
            {tag, " R2 first cycle lanes"}, {8'h0, be_log[0], addr_log[0]},
            {8'h0, exp_be(v.a, n, 0), v.a[19:2], 2'b00});
        if (ecyc == 2)
            chk(addr_log[1] == 20'({v.a[19:2], 2'b00} + 20'd4) && be_log[1] == exp_be(v.a, n, 1),
                {tag, " R3 second cycle lanes"}, {8'h0, be_log[1], addr_log[1]},
                {8'h0, exp_be(v.a, n, 1), 20'({v.a[19:2], 2'b00} + 20'd4)});
        chk(rd == exp_rd, {tag, v.wr ? " R4 R5 write result" : " R5 read data"}, rd, exp_rd);
        @(negedge clk);
        chk(!rsp_valid, {tag, " R8 single pulse"}, 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 8'(i * 37 + 11);
            refb[i] = 8'(i * 37 + 11);
        end
        repeat (3) @(negedge clk);
        chk(req_ready && !bus_valid && !rsp_valid, "R1 reset state",
            {29'h0, req_ready, bus_valid, rsp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_valid && !rsp_valid, "R1 idle after reset",
            {29'h0, req_ready, bus_valid, rsp_valid}, 32'h4);

        for (int i = 0; i < NVEC; i++) run(VEC[i], $sformatf("vec%0d", i));

        // R6: wrap at the top of the address space
        run('{1'b1, 2'd2, 20'hFFFFE, 32'h89ABCDEF}, "R6 wrap write");
        chk(addr_log[0] == 20'hFFFFC && addr_log[1] == 20'h00000, "R6 wrap addresses",
            {12'h0, addr_log[1]}, 32'h0);
        run('{1'b0, 2'd2, 20'hFFFFE, 32'h0}, "R6 wrap read");
        run('{1'b0, 2'd1, 20'h00000, 32'h0}, "R6 low word");

        // R7: stalled bus cycles in both halves of split accesses
        slow = 1'b1;
        for (int i = 2; i < 6; i++) run(VEC[i], $sformatf("slow%0d", i));
        run('{1'b0, 2'd2, 20'hFFFFF, 32'h0}, "R6 slow wrap read");
        slow = 1'b0;
        chk(stall_seen > 0, "R7 stalls exercised", 32'(stall_seen), 32'd1);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule